// File: doc/BRIEF.md
# Configuration Security and Preload Controller

This block guards access to the configuration of a small programmable logic device. A host issues one command at a time on a simple request port. The available commands are: read a fuse location (verify), read or write one byte of an eight-byte user signature, set the one-shot security bit, force the device's output registers to chosen values (preload), and erase everything. The fuse storage itself sits outside the block and is reached through a read strobe, an address and a returned byte. The output registers of the logic array are reached through a per-register preload enable and a preload value.

Once the security bit is set, it blocks two paths. Verify requests never reach the fuse storage, and preload requests never reach the registers. Both then finish with an error strobe. The signature stays readable and writable in either state. Only the erase command returns the block to the unsecured state. Erase also clears the signature and tells the fuse storage to clear itself. Every accepted command runs through a fixed two-cycle sequence, and busy is held high for that whole sequence.

Top module: `cfg_guard`

## Requirements
- R1: While reset is low and in the first cycle after it, busy, rsp_valid, rsp_error, secured, fuse_rd, fuse_clear and pl_en are all 0, and rsp_data and pl_val are 0.
- R2: A request is accepted at a rising edge where cmd_valid is 1 and busy is 0. Busy is then 1 for exactly the next two cycles. Requests presented while busy is 1 are ignored.
- R3: A verify (op 0) with secured at 0 raises fuse_rd for the first busy cycle, with fuse_addr equal to the request address. In the second busy cycle it gives rsp_valid, and rsp_data holds the fuse_rdata byte that was present in the first busy cycle.
- R4: A verify with secured at 1 never raises fuse_rd. It gives rsp_error in the second busy cycle, with rsp_data at 0.
- R5: A signature write (op 2) stores cmd_wdata in byte cmd_addr[2:0]. A signature read (op 1) returns that byte on rsp_data with rsp_valid. Both work whatever the value of secured.
- R6: The security command (op 3) sets secured at the end of its first busy cycle, so the very next accepted command already sees it. Once set, secured changes only through erase.
- R7: A preload (op 4) with secured at 0 drives pl_en = cmd_mask and pl_val = cmd_pval & cmd_mask for the second busy cycle only. Registers whose mask bit is 0 get neither enable nor value.
- R8: A preload with secured at 1 leaves pl_en and pl_val at 0 and gives rsp_error.
- R9: Erase (op 5) clears secured and all eight signature bytes. It pulses fuse_clear for the second busy cycle and gives rsp_valid.
- R10: In the second busy cycle of every command, exactly one of rsp_valid and rsp_error is 1; in every other cycle both are 0. Op codes 6 and 7 give rsp_error. rsp_data is 0 except after a successful verify or signature read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | FUSE_AW (11) | Fuse address, or signature byte index in bits [2:0] |
| cmd_wdata | input | DW (8) | Signature write byte |
| cmd_mask | input | NREG (8) | Preload: registers to force |
| cmd_pval | input | NREG (8) | Preload: values to force |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | Command completed successfully |
| rsp_error | output | 1 | Command blocked or unknown |
| rsp_data | output | DW (8) | Read data |
| secured | output | 1 | Security bit state |
| fuse_rd | output | 1 | Read strobe to fuse storage |
| fuse_addr | output | FUSE_AW (11) | Fuse storage address |
| fuse_rdata | input | DW (8) | Byte returned by fuse storage |
| fuse_clear | output | 1 | Erase pulse to fuse storage |
| pl_en | output | NREG (8) | Per-register preload enable |
| pl_val | output | NREG (8) | Per-register preload value |

## Verification
Two things can meet in one cycle here. The response of a security command can come out in the same cycle that the next request, a verify, is already waiting on the port. The bench never drops cmd_valid between consecutive commands, so each new request sits on the port through the previous command's busy cycles. A behavioural model checks that the waiting request is ignored until busy falls, and then checks that the verify is refused with an error strobe and no fuse read. The same overlap is repeated for preload after security, and for verify after erase.

// File: rtl/cfg_guard.sv
module cfg_guard #(
  parameter int FUSE_AW   = 11,
  parameter int DW        = 8,
  parameter int NREG      = 8,
  parameter int SIG_BYTES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [FUSE_AW-1:0] cmd_addr,
  input  logic [DW-1:0]      cmd_wdata,
  input  logic [NREG-1:0]    cmd_mask,
  input  logic [NREG-1:0]    cmd_pval,
  output logic               busy,
  output logic               rsp_valid,
  output logic               rsp_error,
  output logic [DW-1:0]      rsp_data,
  output logic               secured,
  output logic               fuse_rd,
  output logic [FUSE_AW-1:0] fuse_addr,
  input  logic [DW-1:0]      fuse_rdata,
  output logic               fuse_clear,
  output logic [NREG-1:0]    pl_en,
  output logic [NREG-1:0]    pl_val
);
  localparam int SIG_AW = $clog2(SIG_BYTES);
  localparam logic [2:0] OP_VERIFY  = 3'd0;
  localparam logic [2:0] OP_SIG_RD  = 3'd1;
  localparam logic [2:0] OP_SIG_WR  = 3'd2;
  localparam logic [2:0] OP_SECURE  = 3'd3;
  localparam logic [2:0] OP_PRELOAD = 3'd4;
  localparam logic [2:0] OP_ERASE   = 3'd5;

  typedef enum logic [1:0] {PH_IDLE, PH_EXEC, PH_DONE} phase_t;

  phase_t             ph;
  logic [2:0]         op_q;
  logic [FUSE_AW-1:0] addr_q;
  logic [DW-1:0]      wd_q;
  logic [NREG-1:0]    mask_q, pval_q;
  logic               sec_q;
  logic [DW-1:0]      sig [SIG_BYTES];
  logic               rv_q, re_q, clr_q;
  logic [DW-1:0]      data_q;
  logic [NREG-1:0]    plen_q, plval_q;
  logic [SIG_AW-1:0]  sidx;

  assign sidx       = addr_q[SIG_AW-1:0];
  assign busy       = (ph != PH_IDLE);
  assign secured    = sec_q;
  assign fuse_rd    = (ph == PH_EXEC) && (op_q == OP_VERIFY) && !sec_q;
  assign fuse_addr  = addr_q;
  assign rsp_valid  = rv_q;
  assign rsp_error  = re_q;
  assign rsp_data   = data_q;
  assign fuse_clear = clr_q;
  assign pl_en      = plen_q;
  assign pl_val     = plval_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      mask_q  <= '0;
      pval_q  <= '0;
      sec_q   <= 1'b0;
      rv_q    <= 1'b0;
      re_q    <= 1'b0;
      clr_q   <= 1'b0;
      data_q  <= '0;
      plen_q  <= '0;
      plval_q <= '0;
      for (int i = 0; i < SIG_BYTES; i++) sig[i] <= '0;
    end else begin
      rv_q    <= 1'b0;
      re_q    <= 1'b0;
      clr_q   <= 1'b0;
      data_q  <= '0;
      plen_q  <= '0;
      plval_q <= '0;
      case (ph)
        PH_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          addr_q <= cmd_addr;
          wd_q   <= cmd_wdata;
          mask_q <= cmd_mask;
          pval_q <= cmd_pval;
          ph     <= PH_EXEC;
        end
        PH_EXEC: begin
          ph <= PH_DONE;
          case (op_q)
            OP_VERIFY: begin
              if (sec_q) re_q <= 1'b1;
              else begin
                rv_q   <= 1'b1;
                data_q <= fuse_rdata;
              end
            end
            OP_SIG_RD: begin
              rv_q   <= 1'b1;
              data_q <= sig[sidx];
            end
            OP_SIG_WR: begin
              rv_q      <= 1'b1;
              sig[sidx] <= wd_q;
            end
            OP_SECURE: begin
              rv_q  <= 1'b1;
              sec_q <= 1'b1;
            end
            OP_PRELOAD: begin
              if (sec_q) re_q <= 1'b1;
              else begin
                rv_q    <= 1'b1;
                plen_q  <= mask_q;
                plval_q <= pval_q & mask_q;
              end
            end
            OP_ERASE: begin
              rv_q  <= 1'b1;
              sec_q <= 1'b0;
              clr_q <= 1'b1;
              for (int i = 0; i < SIG_BYTES; i++) sig[i] <= '0;
            end
            default: re_q <= 1'b1;
          endcase
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            rsp_valid,
  input logic            rsp_error,
  input logic            secured,
  input logic            fuse_rd,
  input logic            fuse_clear,
  input logic [NREG-1:0] pl_en
);
  // R10
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_error));
  // R10
  resp_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (rsp_valid ^ rsp_error));
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);
  // R3
  verify_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd |=> (rsp_valid && !secured));
  // R8
  preload_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_en != '0) |-> !secured);
  // R9
  erase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(secured) |-> fuse_clear);
endmodule

bind cfg_guard cfg_guard_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_error(rsp_error), .secured(secured), .fuse_rd(fuse_rd),
  .fuse_clear(fuse_clear), .pl_en(pl_en)
);

// File: tb/cfg_guard_test.sv
module cfg_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [10:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0, cmd_mask = '0, cmd_pval = '0;
  logic        busy, rsp_valid, rsp_error, secured, fuse_rd, fuse_clear;
  logic [7:0]  rsp_data, fuse_rdata, pl_en, pl_val;
  logic [10:0] fuse_addr;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_guard uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_mask(cmd_mask),
    .cmd_pval(cmd_pval), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_error(rsp_error), .rsp_data(rsp_data), .secured(secured),
    .fuse_rd(fuse_rd), .fuse_addr(fuse_addr), .fuse_rdata(fuse_rdata),
    .fuse_clear(fuse_clear), .pl_en(pl_en), .pl_val(pl_val)
  );

  function automatic logic [7:0] fz(input logic [10:0] a);
    return (a[7:0] * 8'd3) ^ {5'b0, a[10:8]} ^ 8'h5A;
  endfunction

  assign fuse_rdata = fuse_rd ? fz(fuse_addr) : 8'hEE;

  // behavioural reference
  int         ph = 0;
  logic [2:0] m_op;
  logic [10:0] m_addr;
  logic [7:0] m_wd, m_mask, m_pval;
  bit         m_sec;
  logic [7:0] m_sig [8];
  bit         e_rv, e_re, e_clr;
  logic [7:0] e_data, e_plen, e_plval;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_sec = 0; e_rv = 0; e_re = 0; e_clr = 0;
      e_data = 0; e_plen = 0; e_plval = 0;
      foreach (m_sig[i]) m_sig[i] = 0;
    end else begin
      e_rv = 0; e_re = 0; e_clr = 0; e_data = 0; e_plen = 0; e_plval = 0;
      if (ph == 0) begin
        if (cmd_valid) begin
          m_op = cmd_op; m_addr = cmd_addr; m_wd = cmd_wdata;
          m_mask = cmd_mask; m_pval = cmd_pval; ph = 1;
        end
      end else if (ph == 1) begin
        ph = 2;
        if (m_op == 0) begin
          if (m_sec) e_re = 1; else begin e_rv = 1; e_data = fz(m_addr); end
        end else if (m_op == 1) begin
          e_rv = 1; e_data = m_sig[m_addr[2:0]];
        end else if (m_op == 2) begin
          e_rv = 1; m_sig[m_addr[2:0]] = m_wd;
        end else if (m_op == 3) begin
          e_rv = 1; m_sec = 1;
        end else if (m_op == 4) begin
          if (m_sec) e_re = 1;
          else begin e_rv = 1; e_plen = m_mask; e_plval = m_pval & m_mask; end
        end else if (m_op == 5) begin
          e_rv = 1; m_sec = 0; e_clr = 1;
          foreach (m_sig[i]) m_sig[i] = 0;
        end else e_re = 1;
      end else ph = 0;
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      if (!rst_n) begin
        cmp("R1 busy", busy, 0);
        cmp("R1 secured", secured, 0);
        cmp("R1 rsp", {rsp_valid, rsp_error, rsp_data}, 0);
        cmp("R1 preload", {pl_en, pl_val, fuse_clear, fuse_rd}, 0);
      end else begin
        cmp("R2 busy", busy, ph != 0);
        cmp("R10 rsp_valid", rsp_valid, e_rv);
        cmp("R10 rsp_error", rsp_error, e_re);
        cmp("R3 R5 R10 rsp_data", rsp_data, e_data);
        cmp("R6 secured", secured, m_sec);
        cmp("R3 R4 fuse_rd", fuse_rd, (ph == 1) && (m_op == 0) && !m_sec);
        if (fuse_rd) cmp("R3 fuse_addr", fuse_addr, m_addr);
        cmp("R7 R8 pl_en", pl_en, e_plen);
        cmp("R7 R8 pl_val", pl_val, e_plval);
        cmp("R9 fuse_clear", fuse_clear, e_clr);
      end
    end
  end

  // presents a request and waits until it is accepted; cmd_valid stays high
  task automatic issue(input logic [2:0] op, input logic [10:0] a,
                       input logic [7:0] wd, input logic [7:0] m, input logic [7:0] pv);
    bit acc;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    cmd_mask = m; cmd_pval = pv;
    do begin
      acc = !busy;
      @(posedge clk);
    end while (!acc);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 3'd7;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    issue(0, 11'h123, 0, 0, 0);        // R3 verify
    issue(0, 11'h7FF, 0, 0, 0);
    idle(3);
    for (int i = 0; i < 8; i++) issue(2, 11'(i), 8'(8'h11 * (i + 1)), 0, 0); // R5
    issue(1, 11'h003, 0, 0, 0);
    issue(1, 11'h7FF, 0, 0, 0);        // index from low bits
    issue(4, 0, 0, 8'hF0, 8'hAA);      // R7
    idle(1);
    issue(4, 0, 0, 8'h00, 8'hFF);
    issue(4, 0, 0, 8'h81, 8'h01);
    issue(6, 0, 0, 0, 0);              // R10 unknown op
    issue(7, 0, 0, 0, 0);
    issue(3, 0, 0, 0, 0);              // R6 secure, verify waiting on the port
    issue(0, 11'h055, 0, 0, 0);        // R4 blocked
    issue(4, 0, 0, 8'hFF, 8'hFF);      // R8 blocked
    issue(1, 11'h005, 0, 0, 0);        // R5 readable while secured
    issue(2, 11'h002, 8'h3C, 0, 0);
    issue(1, 11'h002, 0, 0, 0);
    issue(3, 0, 0, 0, 0);              // R6 stays set
    idle(2);
    issue(5, 0, 0, 0, 0);              // R9 erase
    issue(0, 11'h0AB, 0, 0, 0);        // verify works again
    issue(1, 11'h002, 0, 0, 0);        // signature cleared
    issue(4, 0, 0, 8'h0F, 8'h05);
    idle(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule